// File: doc/BRIEF.md
# Port Pin Pad Control Unit

This block holds the per-pin pad settings for a small group of general-purpose port pins. Software sets, for each pin, a pull enable bit, a drive strength select bit and a slew limit enable bit. The block combines these settings with the pin's live state and drives the pad control lines: pull on, pull polarity, high drive and slew limit. The live state is output direction from the GPIO logic or from a peripheral, analog ownership, and rising-edge interrupt mode.

The pull resistor is resolved by priority. It is forced off while the pin drives out or while an analog function owns the pin. When it is left on and the pin's interrupt detector watches for rising edges, it becomes a pulldown. Drive strength and slew limiting reach the pad only while the pin drives out.

One pin is output-only. Its output function is off after reset and is switched on through a mode register. A second pin belongs to the debug/mode-select function after every reset until software releases it. The pad outputs are combinational, so a change in direction or mode shows in the same cycle.

Top module: `pad_ctl_unit`

## Requirements
- R1: After reset the pull enable and drive registers read 0 and the slew register reads all pins set (low drive, slew limited). The mode register (address 3) reads 0x02: bit0 is the output-only enable and is 0; bit1 is debug ownership and is 1. Every pull_en_o bit is 0.
- R2: A write at address 0 (pull enable), 1 (high drive) or 2 (slew limit) stores one bit per pin, with bit i belonging to pin i. A read of that address returns the stored bits. Bits at and above NPINS read 0, and the pull bit of the output-only pin always reads 0.
- R3: pull_en_o[i] is 0 while gpio_dir[i] or periph_oe[i] is 1, whatever the pull enable bit holds.
- R4: pull_en_o[i] is 0 while analog_own[i] is 1.
- R5: pull_en_o[i] is 1 when pull enable bit i is set, pin i is not driven out and analog_own[i] is 0.
- R6: pull_down_o[i] is 1 exactly when pull_en_o[i] is 1 and rise_det[i] is 1. Otherwise it is 0, which means pullup or no pull.
- R7: drive_high_o[i] and slew_limit_o[i] follow their register bits only while pin i drives out. While the pin is an input they are 0.
- R8: The output-only pin drives out exactly when mode bit0 is 1, and its context inputs are ignored. Its pull_en_o is always 0.
- R9: dbg_owns_o is 1 after reset. It follows mode bit1 after a write to address 3.
- R10: Pad outputs change in the same cycle as the context inputs, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| gpio_dir | input | NPINS | GPIO output direction per pin |
| periph_oe | input | NPINS | Peripheral output enable per pin |
| analog_own | input | NPINS | Analog function owns the pin |
| rise_det | input | NPINS | Interrupt detector set for rising edges |
| pull_en_o | output | NPINS | Pull device on |
| pull_down_o | output | NPINS | Pull polarity: 1 means pulldown |
| drive_high_o | output | NPINS | High drive strength |
| slew_limit_o | output | NPINS | Slew rate limiting on |
| dbg_owns_o | output | 1 | Debug function owns its pin |

## Verification
A register bit held with the wrong value shows up on the read port and on the pad outputs one cycle after the write that should have set it. A wrong priority in the pull resolution shows up at once on pull_en_o or pull_down_o when a direction, analog or edge-mode input toggles, because there is no register between them. The bench therefore checks each pad output on the same cycle as each context change, and checks the read port on the cycle after each write.

// File: rtl/pad_ctl_unit.sv
module pad_ctl_unit #(
  parameter int NPINS   = 6,
  parameter int OO_PIN  = 5,
  parameter int DBG_PIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NPINS-1:0] gpio_dir,
  input  logic [NPINS-1:0] periph_oe,
  input  logic [NPINS-1:0] analog_own,
  input  logic [NPINS-1:0] rise_det,
  output logic [NPINS-1:0] pull_en_o,
  output logic [NPINS-1:0] pull_down_o,
  output logic [NPINS-1:0] drive_high_o,
  output logic [NPINS-1:0] slew_limit_o,
  output logic             dbg_owns_o
);
  localparam logic [NPINS-1:0] OO_MASK = NPINS'(1) << OO_PIN;
  localparam logic [NPINS-1:0] DBG_MASK = NPINS'(1) << DBG_PIN;

  logic [NPINS-1:0] pull_q, drive_q, slew_q;
  logic             oo_en_q, dbg_q;
  logic [NPINS-1:0] is_out, wbits;

  assign wbits = reg_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q  <= '0;
      drive_q <= '0;
      slew_q  <= '1;
      oo_en_q <= 1'b0;
      dbg_q   <= 1'b1;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: pull_q  <= wbits & ~OO_MASK;
        2'd1: drive_q <= wbits;
        2'd2: slew_q  <= wbits;
        default: begin
          oo_en_q <= reg_wdata[0];
          dbg_q   <= reg_wdata[1];
        end
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 8'(pull_q);
      2'd1:    reg_rdata = 8'(drive_q);
      2'd2:    reg_rdata = 8'(slew_q);
      default: reg_rdata = {6'd0, dbg_q, oo_en_q};
    endcase
  end

  assign is_out       = ((gpio_dir | periph_oe) & ~OO_MASK) | (oo_en_q ? OO_MASK : '0);
  assign pull_en_o    = pull_q & ~is_out & ~(analog_own & ~OO_MASK);
  assign pull_down_o  = pull_en_o & rise_det;
  assign drive_high_o = drive_q & is_out;
  assign slew_limit_o = slew_q & is_out;
  assign dbg_owns_o   = dbg_q;

  logic unused_ok;
  assign unused_ok = ^{reg_wdata[7:NPINS], DBG_MASK};
endmodule

// File: rtl/pad_ctl_unit_chk.sv
module pad_ctl_unit_chk #(
  parameter int NPINS  = 6,
  parameter int OO_PIN = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [NPINS-1:0] gpio_dir,
  input logic [NPINS-1:0] periph_oe,
  input logic [NPINS-1:0] analog_own,
  input logic [NPINS-1:0] pull_en_o,
  input logic [NPINS-1:0] pull_down_o,
  input logic [NPINS-1:0] drive_high_o,
  input logic [NPINS-1:0] slew_limit_o,
  input logic             dbg_owns_o
);
  localparam logic [NPINS-1:0] OO_MASK = NPINS'(1) << OO_PIN;

  p_out_no_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((gpio_dir | periph_oe) & ~OO_MASK) & pull_en_o) == '0);
  p_analog_no_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (analog_own & ~OO_MASK & pull_en_o) == '0);
  p_down_needs_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_down_o & ~pull_en_o) == '0);
  p_drive_only_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_high_o | slew_limit_o) & ~(gpio_dir | periph_oe) & ~OO_MASK) == '0);
  p_oo_never_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pull_en_o[OO_PIN]);
  p_dbg_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> (dbg_owns_o == $past(reg_wdata[1])));
endmodule

bind pad_ctl_unit pad_ctl_unit_chk #(.NPINS(NPINS), .OO_PIN(OO_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .gpio_dir(gpio_dir), .periph_oe(periph_oe),
  .analog_own(analog_own), .pull_en_o(pull_en_o), .pull_down_o(pull_down_o),
  .drive_high_o(drive_high_o), .slew_limit_o(slew_limit_o),
  .dbg_owns_o(dbg_owns_o));

// File: tb/pad_ctl_unit_test.sv
module pad_ctl_unit_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [5:0] gpio_dir = 0, periph_oe = 0, analog_own = 0, rise_det = 0;
  logic [5:0] pull_en_o, pull_down_o, drive_high_o, slew_limit_o;
  logic dbg_owns_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pad_ctl_unit uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 pull reg", d, 8'h00);
    rd(1, d); chk("R1 drive reg", d, 8'h00);
    rd(2, d); chk("R1 slew reg", d, 8'h3f);
    rd(3, d); chk("R1 mode reg", d, 8'h02);
    chk("R1 pull out", {2'b0, pull_en_o}, 8'h00);
    chk("R9 dbg reset", {7'b0, dbg_owns_o}, 8'h01);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(0, 8'hff); rd(0, d); chk("R2 pull readback", d, 8'h1f);
    wr(1, 8'hc5); rd(1, d); chk("R2 drive readback", d, 8'h05);
    wr(2, 8'h0a); rd(2, d); chk("R2 slew readback", d, 8'h0a);
  endtask

  task automatic t_pull;
    @(negedge clk);
    gpio_dir = 0; periph_oe = 0; analog_own = 0; rise_det = 0; #1;
    chk("R5 pull on inputs", {2'b0, pull_en_o}, 8'h1f);
    gpio_dir = 6'h01; periph_oe = 6'h02; #1;
    chk("R3 output kills pull", {2'b0, pull_en_o}, 8'h1c);
    analog_own = 6'h04; #1;
    chk("R4 analog kills pull", {2'b0, pull_en_o}, 8'h18);
    rise_det = 6'h39; #1;
    chk("R6 pulldown", {2'b0, pull_down_o}, 8'h18);
    gpio_dir = 0; periph_oe = 0; analog_own = 0; #1;
    chk("R10 same cycle", {2'b0, pull_down_o}, 8'h19);
    rise_det = 0;
  endtask

  task automatic t_drive;
    @(negedge clk);
    wr(1, 8'h3f); wr(2, 8'h3f);
    gpio_dir = 6'h03; periph_oe = 6'h08; #1;
    chk("R7 drive out only", {2'b0, drive_high_o}, 8'h0b);
    chk("R7 slew out only", {2'b0, slew_limit_o}, 8'h0b);
    gpio_dir = 6'h20; periph_oe = 6'h20; analog_own = 6'h20; #1;
    chk("R8 oo ignores context", {2'b0, drive_high_o}, 8'h00);
    wr(3, 8'h03); #1;
    chk("R8 oo enabled", {2'b0, drive_high_o}, 8'h20);
    wr(0, 8'h20); #1;
    chk("R8 oo no pull", {2'b0, pull_en_o}, 8'h00);
    gpio_dir = 0; periph_oe = 0; analog_own = 0;
  endtask

  task automatic t_dbg;
    logic [7:0] d;
    wr(3, 8'h01); #1;
    chk("R9 dbg release", {7'b0, dbg_owns_o}, 8'h00);
    rd(3, d); chk("R9 mode readback", d, 8'h01);
    wr(3, 8'h02); #1;
    chk("R9 dbg regain", {7'b0, dbg_owns_o}, 8'h01);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_regs; t_pull; t_drive; t_dbg;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule